// File: doc/BRIEF.md
# Configurable Byte-Addressed Storage Target

This block is a small storage target that sits behind a single-cycle request/response bus. A request gives a byte offset, an operation (unsigned load, signed load or store), a size code selecting 1, 2, 4 or 8 bytes, and 64 bits of write data. One clock later the block returns a response valid strobe, a success flag and a 64-bit read value. Storage is an internal byte array whose depth is a parameter.

Three configuration controls shape each access. A read-only control turns stores into no-ops that still report success. An endianness control reverses the byte order of multi-byte values between the bus and the array. A 4-bit permission mask, loaded through a write strobe and reset to all sizes allowed, rejects accesses of any size whose bit is clear. Loads zero-extend or sign-extend the bytes they gather to 64 bits. Offsets are assumed to be naturally aligned to the access size.

Top module: `cfg_mem_target`

## Requirements
- R1: Size code 0/1/2/3 selects 1/2/4/8 bytes and is permitted only when mask bit 0/1/2/3 is set. The mask resets to 4'hF. A write through `mask_we` takes effect for requests that arrive in later cycles; a request in the same cycle is judged against the old mask.
- R2: `req_ready` is always high. Each cycle with `req_valid` high produces `rsp_valid` high in the next cycle, together with `rsp_ok`. `rsp_valid` is low in every other cycle. `rsp_rdata` is zero on a failed access and on any store.
- R3: A request whose offset is at or above DEPTH fails and leaves storage unchanged.
- R4: A request whose size bit is clear in the mask fails. A store of that kind leaves storage unchanged.
- R5: With `cfg_le` low, a multi-byte value is stored most-significant byte at the lowest offset.
- R6: With `cfg_le` high, 2-, 4- and 8-byte values are stored least-significant byte at the lowest offset. 1-byte accesses are the same in both modes.
- R7: An unsigned load (op 0) returns the selected bytes zero-extended to 64 bits.
- R8: A signed load (op 1) of 1, 2 or 4 bytes returns the value sign-extended to 64 bits. A signed load of 8 bytes fails.
- R9: With `cfg_rdonly` high, a store (op 2) that is otherwise legal writes nothing and reports success.
- R10: Operation code 3 fails and has no effect.
- R11: A load issued in the cycle right after a store to the same location returns the newly stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_we | input | 1 | Load `mask_wdata` into the size permission mask |
| mask_wdata | input | 4 | New permission mask, bit n allows size code n |
| cfg_rdonly | input | 1 | Read-only mode: stores are dropped but succeed |
| cfg_le | input | 1 | Little-endian byte order for multi-byte data |
| req_valid | input | 1 | Request present this cycle |
| req_ready | output | 1 | Always high: one request accepted per cycle |
| req_offset | input | AW | Byte offset of the access |
| req_op | input | 2 | 0 unsigned load, 1 signed load, 2 store, 3 undefined |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_wdata | input | 64 | Store data, value right-aligned |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_ok | output | 1 | Access succeeded |
| rsp_rdata | output | 64 | Load result, zero on failure or store |

## Verification
Two functions can meet in one cycle. The first case is a mask update that arrives together with a request. The bench drives `mask_we` with a narrowed mask alongside an 8-byte load, and expects the load to be judged against the old mask while the next request sees the new one. The second case is a store followed at once by a load of the same location: the read must see the bytes committed at the edge in between. Random traffic produces both cases again and again, and a bench reference model of the byte array and the mask judges every response.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    typedef enum logic [1:0] {
        OP_LDU = 2'd0,
        OP_LDS = 2'd1,
        OP_ST  = 2'd2,
        OP_BAD = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SZ_1 = 2'd0,
        SZ_2 = 2'd1,
        SZ_4 = 2'd2,
        SZ_8 = 2'd3
    } size_e;

    localparam int unsigned LANES = 8;
    localparam int unsigned DW    = 8 * LANES;

    typedef logic [LANES-1:0][7:0] lanes_t;
endpackage

// File: rtl/cmt_check.sv
module cmt_check
    import cmt_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned AW    = 8
) (
    input  logic [AW-1:0] offset,
    input  op_e            op,
    input  size_e          size,
    input  logic [3:0]     mask,
    output logic           legal,
    output logic           is_store,
    output logic [3:0]     nbytes
);
    logic in_range;
    logic size_ok;
    logic op_ok;

    always_comb begin
        in_range = ({1'b0, offset} < (AW+1)'(DEPTH));
        size_ok  = mask[size];
        op_ok    = (op != OP_BAD) && !((op == OP_LDS) && (size == SZ_8));
        legal    = in_range && size_ok && op_ok;
        is_store = (op == OP_ST);
        nbytes   = 4'd1 << size;
    end
endmodule

// File: rtl/cmt_pack.sv
module cmt_pack
    import cmt_pkg::*;
(
    input  size_e           size,
    input  logic            le,
    input  lanes_t          rd_lanes,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rd_value,
    output lanes_t          wr_lanes
);
    logic [3:0] nb;
    assign nb = 4'd1 << size;

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        always_comb begin
            logic [3:0] src;
            src = le ? 4'(j) : (nb - 4'd1 - 4'(j));
            if (4'(j) < nb) begin
                rd_value[j*8 +: 8] = rd_lanes[src[2:0]];
                wr_lanes[j]        = wdata[src[2:0]*8 +: 8];
            end else begin
                rd_value[j*8 +: 8] = 8'h00;
                wr_lanes[j]        = 8'h00;
            end
        end
    end
endmodule

// File: rtl/cmt_store.sv
module cmt_store
    import cmt_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] offset,
    input  logic [3:0]    nbytes,
    input  lanes_t        wr_lanes,
    output lanes_t        rd_lanes
);
    localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DEPTH-1:0][7:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int i = 0; i < LANES; i++) begin
            logic [AW:0] idx;
            idx = {1'b0, offset} + (AW+1)'(i);
            rd_lanes[i] = (idx < (AW+1)'(DEPTH)) ? mem_q[idx[IW-1:0]] : 8'h00;
            if (we && (4'(i) < nbytes) && (idx < (AW+1)'(DEPTH)))
                mem_d[idx[IW-1:0]] = wr_lanes[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    // R3, R4, R9, R10: storage only changes on an enabled write
    a_r9_hold_unless_write: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(mem_q));
endmodule

// File: rtl/cfg_mem_target.sv
module cfg_mem_target
    import cmt_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mask_we,
    input  logic [3:0]    mask_wdata,
    input  logic          cfg_rdonly,
    input  logic          cfg_le,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_offset,
    input  logic [1:0]    req_op,
    input  logic [1:0]    req_size,
    input  logic [63:0]   req_wdata,
    output logic          rsp_valid,
    output logic          rsp_ok,
    output logic [63:0]   rsp_rdata
);
    typedef struct packed {
        logic [3:0]    mask;
        logic          rvalid;
        logic          ok;
        logic [DW-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    op_e           op;
    size_e         size;
    logic          legal, is_store, store_we;
    logic [3:0]    nbytes;
    lanes_t        rd_lanes, wr_lanes;
    logic [DW-1:0] raw_val, ext_val;

    assign op        = op_e'(req_op);
    assign size      = size_e'(req_size);
    assign req_ready = 1'b1;

    cmt_check #(.DEPTH(DEPTH), .AW(AW)) u_check (
        .offset  (req_offset),
        .op      (op),
        .size    (size),
        .mask    (st_q.mask),
        .legal   (legal),
        .is_store(is_store),
        .nbytes  (nbytes)
    );

    cmt_pack u_pack (
        .size    (size),
        .le      (cfg_le),
        .rd_lanes(rd_lanes),
        .wdata   (req_wdata),
        .rd_value(raw_val),
        .wr_lanes(wr_lanes)
    );

    cmt_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (store_we),
        .offset  (req_offset),
        .nbytes  (nbytes),
        .wr_lanes(wr_lanes),
        .rd_lanes(rd_lanes)
    );

    always_comb begin
        ext_val = raw_val;
        if (op == OP_LDS) begin
            unique case (size)
                SZ_1:    ext_val = {{56{raw_val[7]}},  raw_val[7:0]};
                SZ_2:    ext_val = {{48{raw_val[15]}}, raw_val[15:0]};
                SZ_4:    ext_val = {{32{raw_val[31]}}, raw_val[31:0]};
                default: ext_val = raw_val;
            endcase
        end

        store_we = req_valid && legal && is_store && !cfg_rdonly;

        st_d        = st_q;
        st_d.mask   = mask_we ? mask_wdata : st_q.mask;
        st_d.rvalid = req_valid;
        st_d.ok     = req_valid && legal;
        st_d.rdata  = (req_valid && legal && !is_store) ? ext_val : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mask   <= 4'hF;
            st_q.rvalid <= 1'b0;
            st_q.ok     <= 1'b0;
            st_q.rdata  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rvalid;
    assign rsp_ok    = st_q.ok;
    assign rsp_rdata = st_q.rdata;

    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r2_fail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |-> (rsp_rdata == 64'd0));
    a_r3_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ({1'b0, req_offset} >= (AW+1)'(DEPTH))) |=> !rsp_ok);
    a_r4_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !st_q.mask[req_size]) |=> !rsp_ok);
    a_r4_no_store_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !st_q.mask[req_size]) |-> !store_we);
    a_r7_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd0 && req_size == 2'd1) |=> (rsp_rdata[63:16] == 48'd0));
    a_r8_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd1 && req_size == 2'd0) |=> (rsp_rdata[63:8] == {56{rsp_rdata[7]}}));
    a_r8_signed_wide_fails: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd1 && req_size == 2'd3) |=> !rsp_ok);
    a_r10_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd3) |=> !rsp_ok);
endmodule

// File: tb/cfg_mem_target_bench.sv
module cfg_mem_target_bench;
    localparam int unsigned DEPTH = 64;
    localparam int unsigned AW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mask_we = 1'b0;
    logic [3:0]    mask_wdata = 4'h0;
    logic          cfg_rdonly = 1'b0;
    logic          cfg_le = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_offset = '0;
    logic [1:0]    req_op = 2'd0;
    logic [1:0]    req_size = 2'd0;
    logic [63:0]   req_wdata = '0;
    logic          rsp_valid, rsp_ok;
    logic [63:0]   rsp_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0]  ref_mem [DEPTH];
    logic [3:0]  ref_mask = 4'hF;
    logic        got_ok;
    logic [63:0] got_rd;

    always #5 clk = ~clk;

    cfg_mem_target #(.DEPTH(DEPTH), .AW(AW)) u_cfg_mem_target (
        .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .cfg_rdonly(cfg_rdonly), .cfg_le(cfg_le), .req_valid(req_valid),
        .req_ready(req_ready), .req_offset(req_offset), .req_op(req_op),
        .req_size(req_size), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_ok(rsp_ok), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_load(input int off, input int sz, input bit sgn, input bit le);
        int n;
        logic [63:0] v;
        n = 1 << sz;
        v = '0;
        for (int j = 0; j < n; j++) begin
            int src;
            src = le ? j : n - 1 - j;
            v[j*8 +: 8] = ref_mem[off + src];
        end
        if (sgn && n < 8 && v[8*n-1]) v = v | ~((64'd1 << (8*n)) - 64'd1);
        return v;
    endfunction

    task automatic xact(input logic [1:0] op, input logic [1:0] sz, input int off,
                        input logic [63:0] wd, input logic ro, input logic le,
                        input logic mwe, input logic [3:0] md, input string tag);
        bit legal;
        logic [63:0] exp;
        int n;
        n = 1 << sz;
        legal = (op != 2'd3) && (off < DEPTH) && ref_mask[sz] && !(op == 2'd1 && sz == 2'd3);
        exp = (legal && op != 2'd2) ? exp_load(off, int'(sz), op == 2'd1, le) : 64'd0;
        req_valid  = 1'b1;
        req_op     = op;
        req_size   = sz;
        req_offset = AW'(off);
        req_wdata  = wd;
        cfg_rdonly = ro;
        cfg_le     = le;
        mask_we    = mwe;
        mask_wdata = md;
        @(negedge clk);
        got_ok = rsp_ok;
        got_rd = rsp_rdata;
        chk(rsp_valid && req_ready, {tag, " R2 response strobe"}, 64'(rsp_valid), 64'd1);
        chk(rsp_ok == legal, {tag, " ok flag"}, 64'(rsp_ok), 64'(legal));
        chk(rsp_rdata == exp, {tag, " read data"}, rsp_rdata, exp);
        if (legal && op == 2'd2 && !ro)
            for (int i = 0; i < n; i++)
                ref_mem[off + i] = le ? wd[i*8 +: 8] : wd[(n-1-i)*8 +: 8];
        if (mwe) ref_mask = md;
        req_valid = 1'b0;
        mask_we   = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #2000000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'h00;
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: idle after reset
        chk(!rsp_valid, "R2 reset idle", 64'(rsp_valid), 64'd0);
        // R1: default mask permits 8-byte access
        xact(2'd0, 2'd3, 0, 0, 0, 0, 0, 0, "R1 reset mask");
        chk(got_ok, "R1 8-byte allowed after reset", 64'(got_ok), 64'd1);

        // R5: big-endian order
        xact(2'd2, 2'd3, 0, 64'h0102030405060708, 0, 0, 0, 0, "R5 store");
        xact(2'd0, 2'd0, 0, 0, 0, 0, 0, 0, "R5 lowest byte");
        chk(got_rd == 64'h01, "R5 msb at low offset", got_rd, 64'h01);
        xact(2'd0, 2'd0, 7, 0, 0, 1, 0, 0, "R6 byte unaffected by le");
        chk(got_rd == 64'h08, "R6 byte access same in le", got_rd, 64'h08);

        // R6: little-endian order
        xact(2'd2, 2'd2, 8, 64'hAABBCCDD, 0, 1, 0, 0, "R6 store");
        xact(2'd0, 2'd0, 8, 0, 0, 0, 0, 0, "R6 low byte");
        chk(got_rd == 64'hDD, "R6 lsb at low offset", got_rd, 64'hDD);
        xact(2'd0, 2'd2, 8, 0, 0, 0, 0, 0, "R7 reversed view");
        chk(got_rd == 64'hDDCCBBAA, "R7 zero-extended reversed", got_rd, 64'hDDCCBBAA);

        // R8: sign extension and wide signed failure
        xact(2'd1, 2'd2, 8, 0, 0, 0, 0, 0, "R8 signed word");
        chk(got_rd == 64'hFFFFFFFF_DDCCBBAA, "R8 sign extension", got_rd, 64'hFFFFFFFF_DDCCBBAA);
        xact(2'd1, 2'd3, 0, 0, 0, 0, 0, 0, "R8 signed 8-byte");
        chk(!got_ok, "R8 signed 8-byte fails", 64'(got_ok), 64'd0);

        // R9: read-only store dropped
        xact(2'd2, 2'd1, 16, 64'hBEEF, 1, 0, 0, 0, "R9 rdonly store");
        chk(got_ok, "R9 rdonly store reports ok", 64'(got_ok), 64'd1);
        xact(2'd0, 2'd1, 16, 0, 0, 0, 0, 0, "R9 readback");
        chk(got_rd == 64'd0, "R9 storage untouched", got_rd, 64'd0);

        // R3: out of range
        xact(2'd2, 2'd0, DEPTH, 64'h55, 0, 0, 0, 0, "R3 store beyond");
        chk(!got_ok, "R3 store beyond fails", 64'(got_ok), 64'd0);
        xact(2'd0, 2'd0, DEPTH + 8, 0, 0, 0, 0, 0, "R3 load beyond");

        // R1/R4: mask change together with a request
        xact(2'd0, 2'd3, 0, 0, 0, 0, 1, 4'b0001, "R1 same-cycle mask");
        chk(got_ok, "R1 old mask applies", 64'(got_ok), 64'd1);
        xact(2'd0, 2'd3, 0, 0, 0, 0, 0, 0, "R4 masked load");
        chk(!got_ok, "R4 new mask blocks", 64'(got_ok), 64'd0);
        xact(2'd2, 2'd1, 24, 64'h1234, 0, 0, 0, 0, "R4 masked store");
        xact(2'd0, 2'd0, 24, 0, 0, 0, 1, 4'hF, "R4 byte still allowed");
        xact(2'd0, 2'd1, 24, 0, 0, 0, 0, 0, "R4 readback");
        chk(got_rd == 64'd0, "R4 masked store wrote nothing", got_rd, 64'd0);

        // R10: undefined op
        xact(2'd3, 2'd0, 0, 64'hFF, 0, 0, 0, 0, "R10 bad op");
        xact(2'd0, 2'd0, 0, 0, 0, 0, 0, 0, "R10 readback");
        chk(got_rd == 64'h01, "R10 no effect", got_rd, 64'h01);

        // R11: store then load back to back
        xact(2'd2, 2'd3, 32, 64'hCAFE_F00D_1357_9BDF, 0, 1, 0, 0, "R11 store");
        xact(2'd0, 2'd3, 32, 0, 0, 1, 0, 0, "R11 load");
        chk(got_rd == 64'hCAFE_F00D_1357_9BDF, "R11 fresh data", got_rd, 64'hCAFE_F00D_1357_9BDF);

        @(negedge clk);
        chk(!rsp_valid, "R2 idle no response", 64'(rsp_valid), 64'd0);

        // Random traffic mixing all requirements
        for (int k = 0; k < 600; k++) begin
            logic [1:0] op, sz;
            int off;
            logic [63:0] wd;
            logic mwe;
            logic [3:0] md;
            op  = 2'($urandom % 4);
            if ($urandom % 8 == 0) op = 2'd3; else if (op == 2'd3) op = 2'd2;
            sz  = 2'($urandom % 4);
            off = int'(($urandom % 80) & ~((1 << sz) - 1));
            wd  = {$urandom, $urandom};
            mwe = ($urandom % 16 == 0);
            md  = 4'($urandom) | 4'b0001;
            if ($urandom % 4 == 0) md = 4'hF;
            xact(op, sz, off, wd, ($urandom % 8 == 0), 1'($urandom), mwe, md, "R2 R7 random");
            if ($urandom % 5 == 0) begin
                @(negedge clk);
                chk(!rsp_valid, "R2 random idle", 64'(rsp_valid), 64'd0);
            end
        end
        finish_run();
    end
endmodule